// File: doc/BRIEF.md
# Pipeline Hazard Stall and Forwarding Controller

This block decides, every cycle, whether a five-stage in-order pipeline may advance and where the two execute-stage operands come from. It compares the source registers of the instruction being decoded against the destinations of the two older instructions still in execute and memory, and uses a static forwarding policy to resolve any true dependence. It then either asks for forwarding or freezes the front of the pipeline while a bubble goes downstream. Only read-after-write matters. Write-after-read and write-after-write pairs are ignored. A producer that has reached write-back needs nothing, because the register file writes early in the cycle and reads late.

Two further stall sources feed the same freeze decision. The first is a fetch that loses to a data access on a single shared memory. The second is a stall-on-branch wait whose length follows the stage in which branches resolve. The operand selects are registered: they are worked out while the consumer sits in decode and presented during the cycle that consumer spends in execute.

Top module: `hzc_unit`

## Requirements
- R1: A producer with write enable low never causes a stall or a forward, even when its destination equals a source being decoded.
- R2: A source or destination of register 0 never matches, so it causes no stall and its operand select stays 0 (register file).
- R3: With mode 0 (or 3), no forwarding: a consumer right behind its producer gets two bubbles, one two places behind gets one bubble, and the operand selects are always 0.
- R4: With mode 1, full forwarding, an ALU producer in execute causes no stall and the matching select becomes 1 (from execute/memory latch) in the next cycle. A producer in memory yields select 2 (from memory/write-back latch).
- R5: With mode 1, a load in execute feeding the decoded instruction costs exactly one bubble, after which the select becomes 2.
- R6: With mode 2, ALU-to-ALU only, an ALU producer in execute is forwarded with select 1. A producer in memory causes one bubble. Loads stall as in mode 0, and select 2 never appears.
- R7: When execute and memory both write the requested register, the younger producer in execute decides both the stall and the select.
- R8: A stall raises the PC/fetch-latch hold and the decode/execute bubble together in the same cycle. The operand selects in the following cycle are 0.
- R9: When the memory stage makes a data access, hold and bubble are raised in that cycle.
- R10: A branch in decode that is not itself stalled starts a wait of 1, 2 or 3 held cycles for resolution-stage code 0 (decode), 1 (execute) or 2 (memory); code 3 behaves as 2. Branch flags seen during a wait are ignored.
- R11: While reset is low the selects read 0, and no branch wait begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_mode_i | input | 2 | Forwarding policy: 0 none, 1 full, 2 ALU-to-ALU only, 3 none |
| br_stage_i | input | 2 | Branch resolution stage: 0 decode, 1 execute, 2/3 memory |
| id_rs1_i | input | REG_W | First source register of decoded instruction |
| id_rs2_i | input | REG_W | Second source register of decoded instruction |
| id_branch_i | input | 1 | Decoded instruction is a branch |
| ex_rd_i | input | REG_W | Destination of instruction in execute |
| ex_we_i | input | 1 | Instruction in execute writes a register |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | REG_W | Destination of instruction in memory |
| mem_we_i | input | 1 | Instruction in memory writes a register |
| mem_dacc_i | input | 1 | Memory stage uses the shared memory this cycle |
| pc_hold_o | output | 1 | Hold PC and fetch/decode latch |
| idex_bubble_o | output | 1 | Load a bubble with zeroed controls into decode/execute latch |
| fwd_a_o | output | 2 | Operand A select in execute: 0 file, 1 exe/mem, 2 mem/wb |
| fwd_b_o | output | 2 | Operand B select in execute: 0 file, 1 exe/mem, 2 mem/wb |

## Verification
The bench keeps the default 5-bit register numbers, so registers 5, 6 and 0 can act as live and hardwired sources. It sweeps all four resolution-stage codes, which exercises every length of branch wait. It also changes the forwarding mode between sequences and replays the same producer patterns at distances one and two, so each policy's stall count and select value can be compared side by side. Collisions are covered as well: two producers writing one register, and a branch arriving while a data stall is active.

// File: rtl/hzc_pkg.sv
// Shared encodings for the hazard controller.
// Assumes two-bit mode and select fields as listed in the brief.
package hzc_pkg;
    typedef enum logic [1:0] {
        FWD_NONE = 2'd0,
        FWD_FULL = 2'd1,
        FWD_ALU  = 2'd2,
        FWD_RSVD = 2'd3
    } fwd_mode_e;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } opsel_e;
endpackage

// File: rtl/hzc_src_check.sv
// Per-source dependence check.
// Compares one decode source register with the execute and memory
// destinations. It reports whether the source must wait, and which
// forward the source will take once it reaches execute.
// Assumes a write-back producer is already visible through the register file.
module hzc_src_check
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fwd_mode_e        mode_i,
    input  logic [REG_W-1:0] rs_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_we_i,
    input  logic             ex_load_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_we_i,
    output logic             stall_o,
    output opsel_e           sel_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic ex_hit;
    logic mem_hit;

    // Match producers; the younger one in execute masks the older one.
    always_comb begin
        ex_hit  = ex_we_i && (ex_rd_i != ZERO_REG) && (ex_rd_i == rs_i);
        mem_hit = mem_we_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == rs_i) && !ex_hit;
    end

    // Apply the forwarding policy to the youngest match.
    always_comb begin
        case (mode_i)
            FWD_FULL: begin
                stall_o = ex_hit && ex_load_i;
                sel_o   = ex_hit ? SEL_EXMEM : (mem_hit ? SEL_MEMWB : SEL_RF);
            end
            FWD_ALU: begin
                stall_o = (ex_hit && ex_load_i) || mem_hit;
                sel_o   = (ex_hit && !ex_load_i) ? SEL_EXMEM : SEL_RF;
            end
            default: begin
                stall_o = ex_hit || mem_hit;
                sel_o   = SEL_RF;
            end
        endcase
    end

    // R2
    zero_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_i == ZERO_REG) |-> (!stall_o && sel_o == SEL_RF));

    // R1
    no_write_no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we_i && !mem_we_i) |-> (!stall_o && sel_o == SEL_RF));
endmodule

// File: rtl/hzc_branch_timer.sv
// Stall-on-branch wait counter.
// It loads a length from the resolution stage when a branch leaves
// decode, and it stays busy until the count reaches zero.
// Assumes start is only raised while not busy.
module hzc_branch_timer #(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] stage_i,
    output logic       busy_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    // Decode the resolution stage into a wait length.
    always_comb begin
        case (stage_i)
            2'd0:    len = CNT_W'(1);
            2'd1:    len = CNT_W'(2);
            default: len = CNT_W'(3);
        endcase
    end

    // Load on start, count down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy_o = (cnt_q != '0);

    // R10
    start_makes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R10
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/hzc_unit.sv
// Hazard controller top.
// Merges data-dependence stalls, shared-memory fetch conflicts and
// branch waits into one freeze signal. It also registers the operand
// selects for the instruction entering execute.
// Assumes a held decode instruction is re-checked every cycle.
module hzc_unit
    import hzc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int BR_CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fwd_mode_i,
    input  logic [1:0]       br_stage_i,
    input  logic [REG_W-1:0] id_rs1_i,
    input  logic [REG_W-1:0] id_rs2_i,
    input  logic             id_branch_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_we_i,
    input  logic             ex_load_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_we_i,
    input  logic             mem_dacc_i,
    output logic             pc_hold_o,
    output logic             idex_bubble_o,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o
);
    localparam int NSRC = 2;

    fwd_mode_e        mode;
    logic [REG_W-1:0] src   [NSRC];
    logic             stall_v [NSRC];
    opsel_e           sel_v   [NSRC];
    logic [1:0]       sel_q   [NSRC];
    logic             data_stall;
    logic             br_busy;
    logic             br_start;
    logic             freeze;

    assign mode   = fwd_mode_e'(fwd_mode_i);
    assign src[0] = id_rs1_i;
    assign src[1] = id_rs2_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzc_src_check #(.REG_W(REG_W)) u_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode),
            .rs_i     (src[g]),
            .ex_rd_i  (ex_rd_i),
            .ex_we_i  (ex_we_i),
            .ex_load_i(ex_load_i),
            .mem_rd_i (mem_rd_i),
            .mem_we_i (mem_we_i),
            .stall_o  (stall_v[g]),
            .sel_o    (sel_v[g])
        );

        // Register the select for the cycle the consumer spends in execute.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= 2'd0;
            else if (freeze)
                sel_q[g] <= 2'd0;
            else
                sel_q[g] <= sel_v[g];
        end
    end

    // Combine all stall sources into one freeze decision.
    always_comb begin
        data_stall = stall_v[0] || stall_v[1];
        br_start   = id_branch_i && !data_stall && !mem_dacc_i && !br_busy;
        freeze     = data_stall || mem_dacc_i || br_busy;
    end

    hzc_branch_timer #(.CNT_W(BR_CNT_W)) u_br (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(br_start),
        .stage_i(br_stage_i),
        .busy_o (br_busy)
    );

    assign pc_hold_o     = freeze;
    assign idex_bubble_o = freeze;
    assign fwd_a_o       = sel_q[0];
    assign fwd_b_o       = sel_q[1];

    // R9
    fetch_conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dacc_i |-> (pc_hold_o && idex_bubble_o));

    // R8
    bubble_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble_o |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));

    // R6
    alu_mode_no_memwb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FWD_ALU) |=> (fwd_a_o != 2'd2 && fwd_b_o != 2'd2));

    // R3
    none_mode_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FWD_NONE || mode == FWD_RSVD) |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
endmodule

// File: tb/tb_hzc_unit.sv
`timescale 1ns/1ps
module tb_hzc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fwd_mode = 2'd0;
    logic [1:0] br_stage = 2'd0;
    logic [4:0] rs1 = '0, rs2 = '0, exrd = '0, memrd = '0;
    logic       br = 1'b0, exwe = 1'b0, exld = 1'b0, memwe = 1'b0, dacc = 1'b0;
    logic       pc_hold, idex_bubble;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit         q_hold [$];
    logic [1:0] q_a [$];
    logic [1:0] q_b [$];
    string      q_tag [$];

    always #2 clk = ~clk;

    hzc_unit dut (
        .clk(clk), .rst_n(rst_n), .fwd_mode_i(fwd_mode), .br_stage_i(br_stage),
        .id_rs1_i(rs1), .id_rs2_i(rs2), .id_branch_i(br),
        .ex_rd_i(exrd), .ex_we_i(exwe), .ex_load_i(exld),
        .mem_rd_i(memrd), .mem_we_i(memwe), .mem_dacc_i(dacc),
        .pc_hold_o(pc_hold), .idex_bubble_o(idex_bubble),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b)
    );

    // Driver: apply one cycle of stimulus and queue what the requirements predict.
    task automatic cyc(input logic [1:0] m, input logic [4:0] a1, input logic [4:0] a2,
                       input logic b, input logic [1:0] bs,
                       input logic [4:0] er, input logic ew, input logic el,
                       input logic [4:0] mr, input logic mw, input logic da,
                       input bit h, input logic [1:0] ea, input logic [1:0] eb,
                       input string tag);
        @(negedge clk);
        fwd_mode = m; rs1 = a1; rs2 = a2; br = b; br_stage = bs;
        exrd = er; exwe = ew; exld = el; memrd = mr; memwe = mw; dacc = da;
        q_hold.push_back(h); q_a.push_back(ea); q_b.push_back(eb); q_tag.push_back(tag);
    endtask

    // Monitor: hold is checked mid-cycle, the selects just after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q_hold.size() > 0) begin
                bit h;
                logic [1:0] ea, eb;
                string tag;
                h = q_hold.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
                tag = q_tag.pop_front();
                checks++;
                if (pc_hold !== h || idex_bubble !== h) begin
                    fails++;
                    $display("FAIL %s hold: got %b/%b expected %b", tag, pc_hold, idex_bubble, h);
                end
                @(posedge clk);
                #1;
                checks++;
                if (fwd_a !== ea) begin
                    fails++;
                    $display("FAIL %s sel_a: got %0d expected %0d", tag, fwd_a, ea);
                end
                checks++;
                if (fwd_b !== eb) begin
                    fails++;
                    $display("FAIL %s sel_b: got %0d expected %0d", tag, fwd_b, eb);
                end
            end
        end
    end

    initial begin
        // R11 reset: branch request ignored, selects zero
        cyc(1, 5, 6, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 reset br");
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 reset idle");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 after reset");

        // R3 no forwarding
        cyc(0, 5, 6, 0, 0, 5, 1, 0, 0, 0, 0, 1, 0, 0, "R3 dist1 bubble1");
        cyc(0, 5, 6, 0, 0, 0, 0, 0, 5, 1, 0, 1, 0, 0, "R3 dist1 bubble2");
        cyc(0, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 writeback free");
        cyc(0, 5, 6, 0, 0, 0, 0, 0, 6, 1, 0, 1, 0, 0, "R3 dist2 bubble");
        cyc(3, 5, 6, 0, 0, 6, 1, 0, 0, 0, 0, 1, 0, 0, "R3 mode3 as none");
        cyc(0, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 idle");

        // R1 and R2
        cyc(1, 5, 6, 0, 0, 5, 0, 0, 6, 0, 0, 0, 0, 0, "R1 no write enable");
        cyc(1, 0, 6, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R2 zero reg full");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, "R2 zero reg none");

        // R4 full forwarding of ALU results
        cyc(1, 5, 6, 0, 0, 5, 1, 0, 0, 0, 0, 0, 1, 0, "R4 ex alu fwd");
        cyc(1, 5, 6, 0, 0, 0, 0, 0, 6, 1, 0, 0, 0, 2, "R4 mem fwd");
        cyc(1, 5, 6, 0, 0, 6, 1, 0, 5, 1, 0, 0, 2, 1, "R4 both sources");

        // R5 load-use in full mode
        cyc(1, 5, 6, 0, 0, 6, 1, 1, 0, 0, 0, 1, 0, 0, "R5 load bubble");
        cyc(1, 5, 6, 0, 0, 0, 0, 0, 6, 1, 0, 0, 0, 2, "R5 load forward");

        // R6 ALU-to-ALU only
        cyc(2, 5, 6, 0, 0, 5, 1, 0, 0, 0, 0, 0, 1, 0, "R6 alu next");
        cyc(2, 5, 6, 0, 0, 0, 0, 0, 5, 1, 0, 1, 0, 0, "R6 dist2 stall");
        cyc(2, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");
        cyc(2, 5, 6, 0, 0, 6, 1, 1, 0, 0, 0, 1, 0, 0, "R6 load bubble1");
        cyc(2, 5, 6, 0, 0, 0, 0, 0, 6, 1, 0, 1, 0, 0, "R6 load bubble2");
        cyc(2, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 load done");

        // R7 youngest producer wins
        cyc(1, 5, 5, 0, 0, 5, 1, 0, 5, 1, 0, 0, 1, 1, "R7 full youngest");
        cyc(2, 5, 6, 0, 0, 5, 1, 0, 5, 1, 0, 0, 1, 0, "R7 alu youngest");
        cyc(1, 5, 6, 0, 0, 5, 1, 1, 5, 1, 0, 1, 0, 0, "R7 young load stalls");

        // R9 shared memory fetch conflict, R8 bubble clears selects
        cyc(1, 5, 6, 0, 0, 5, 1, 0, 0, 0, 1, 1, 0, 0, "R9 conflict with hit R8");
        cyc(1, 5, 6, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9 conflict alone");
        cyc(1, 5, 6, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9 branch blocked");
        cyc(1, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 release");

        // R10 branch waits per resolution stage
        cyc(1, 5, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 id branch");
        cyc(1, 5, 6, 0, 0, 5, 1, 0, 0, 0, 0, 1, 0, 0, "R10 id wait R8");
        cyc(1, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 id done");
        cyc(1, 5, 6, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 ex branch");
        cyc(1, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 ex wait1");
        cyc(1, 5, 6, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 ex wait2 br ignored");
        cyc(1, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 ex done");
        cyc(1, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 no restart");
        cyc(1, 5, 6, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 mem branch");
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 mem wait1");
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 mem wait2");
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 mem wait3");
        cyc(1, 5, 6, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 mem done");
        cyc(1, 5, 6, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 code3 branch");
        cyc(1, 5, 6, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 code3 wait1");
        cyc(1, 5, 6, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 code3 wait2");
        cyc(1, 5, 6, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 code3 wait3");
        cyc(1, 5, 6, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 code3 done");
        cyc(0, 5, 6, 1, 1, 5, 1, 0, 0, 0, 0, 1, 0, 0, "R10 branch data stall1");
        cyc(0, 5, 6, 1, 1, 0, 0, 0, 5, 1, 0, 1, 0, 0, "R10 branch data stall2");
        cyc(0, 5, 6, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 branch leaves");
        cyc(0, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 late wait1");
        cyc(0, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 late wait2");
        cyc(0, 5, 6, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 late done");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule